// File: doc/BRIEF.md
# Pseudorandom Sequence Receiver with Lock Tracking and Error Totals

The block takes an incoming test stream and checks it against a maximal-length pseudorandom sequence. The receiver is given the register length and the feedback tap set at run time. Each valid cycle brings one bit, one 4-bit word or one 8-bit word. While the receiver is hunting for the pattern, each received bit goes straight into a local shift register. Every bit is also compared against the prediction that this register makes. After a run of correct predictions twice the register length long, the receiver declares lock. From then on the register runs on its own predictions, so a corrupted input bit costs exactly one error and does not spoil later predictions.

While lock is held, the block keeps two wide totals: the number of bits examined and the number that mismatched. Their ratio gives the error rate. A latch command copies both totals into holding registers so they can be read out together, and it restarts the live totals in the same cycle so that no bit is lost between readouts. Lock tolerates an error rate of one in a hundred. When six or more errors fall inside one 64-bit observation window, the receiver drops lock and hunts again.

Top module: `prbs_rx`

## Requirements
- R1: `mode_i` selects the word size: 0 takes `data_i[0]`, 1 takes `data_i[3:0]`, 2 takes `data_i[7:0]`, and 3 behaves as 0. Within a word, the most significant bit in use is the earliest bit of the sequence.
- R2: While unlocked, every received bit is shifted into the local register at bit 0, and its prediction is scored. `sync_o` rises after the clock edge on which the run of consecutive correct predictions reaches 2n, where n = `len_i` + 1.
- R3: While locked, the local register advances on its own predicted bits, so one flipped input bit adds exactly one to the error total.
- R4: Lock is tracked in consecutive 64-bit windows, the first of which starts at lock. The word that brings the error count of the current window to 6 or more makes `sync_o` fall after that edge, and acquisition restarts with a zero run.
- R5: With one error every 100 bits, evenly spread, `sync_o` stays high once it has risen.
- R6: On each valid word that arrives while `sync_o` is high, the bit total grows by the word size. Nothing is counted while `sync_o` is low.
- R7: On each valid word that arrives while `sync_o` is high, the error total grows by that word's number of mismatched bits, which is 0 to 8.
- R8: When `latch_i` is high, the holding outputs take the live totals as they stood before the edge, and the live totals restart from that cycle's own contribution. When `latch_i` is low, the holding outputs do not change.
- R9: Both totals saturate at all ones instead of wrapping.
- R10: A cycle with `valid_i` low changes neither the lock state, the local register, the run count nor the totals.
- R11: The prediction is the XOR of bit k of the local register for every k < n with `taps_i[k]` set; bit k holds the bit received k+1 positions earlier. Tap bits at k ≥ n are ignored.
- R12: Reset clears lock, the local register, the run count, the windows and all four totals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Data word present this cycle |
| mode_i | input | 2 | Word size select |
| data_i | input | WORD_W | Received data word |
| len_i | input | LEN_W | Register length minus one |
| taps_i | input | MAX_LEN | Feedback tap mask |
| latch_i | input | 1 | Copy totals to holding outputs and restart them |
| sync_o | output | 1 | Receiver is locked |
| bit_hold_o | output | CNT_W | Latched bit total |
| err_hold_o | output | CNT_W | Latched error total |

## Verification
If the local register holds a wrong value, the effect shows on `sync_o` within one observation window. During hunting it shows as a lock that comes a word early or late. While locked, predictions go wrong and the receiver drops lock after at most 64 bits. A wrong tap mask, a wrong bit order or an off-by-one in the window appears as a lock edge in a different cycle from the one the bench expects, and the bench compares `sync_o` on every cycle. Faults in the counting and saturation show only at the next latch, where both holding values are compared against totals that the bench maintains itself.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;
  typedef enum logic [1:0] {
    WM_SER  = 2'd0,
    WM_NIB  = 2'd1,
    WM_BYTE = 2'd2,
    WM_RSV  = 2'd3
  } wmode_e;

  localparam int WIN_BITS = 64;
  localparam int WIN_ERRS = 6;
endpackage

// File: rtl/prbs_rx_step.sv
// One word through the local register, earliest bit first.
module prbs_rx_step #(
  parameter int MAX_LEN = 32,
  parameter int WORD_W  = 8,
  parameter int RUN_W   = 7,
  parameter int NB_W    = 4
) (
  input  logic [MAX_LEN-1:0] state_i,
  input  logic [MAX_LEN-1:0] taps_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic [NB_W-1:0]    nb_i,
  input  logic               locked_i,
  input  logic [RUN_W-1:0]   run_i,
  output logic [MAX_LEN-1:0] state_o,
  output logic [RUN_W-1:0]   run_o,
  output logic [NB_W-1:0]    miss_o
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [MAX_LEN-1:0] st;
  logic [RUN_W-1:0]   run;
  logic [NB_W-1:0]    miss;
  logic [IDX_W-1:0]   idx;
  logic               p, d;

  always_comb begin
    st   = state_i;
    run  = run_i;
    miss = '0;
    idx  = '0;
    p    = 1'b0;
    d    = 1'b0;
    for (int j = 0; j < WORD_W; j++) begin
      if (j < int'(nb_i)) begin
        idx = IDX_W'(int'(nb_i) - 1 - j);
        d   = data_i[idx];
        p   = ^(st & taps_i);
        if (p != d) begin
          miss = miss + NB_W'(1);
          run  = '0;
        end else if (run != '1) begin
          run = run + RUN_W'(1);
        end
        // locked: run free on prediction; hunting: take the line
        st = {st[MAX_LEN-2:0], locked_i ? p : d};
      end
    end
    state_o = st;
    run_o   = run;
    miss_o  = miss;
  end
endmodule

// File: rtl/prbs_rx_sync.sv
module prbs_rx_sync
  import prbs_rx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int RUN_W  = 7,
  parameter int NB_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [NB_W-1:0]  nb_i,
  input  logic [NB_W-1:0]  miss_i,
  input  logic [RUN_W-1:0] run_next_i,
  input  logic [RUN_W-1:0] need_i,
  output logic             locked_o,
  output logic [RUN_W-1:0] run_o
);
  localparam int WIN_W = $clog2(WIN_BITS + WORD_W + 1);

  logic             locked_q;
  logic [RUN_W-1:0] run_q;
  logic [WIN_W-1:0] win_b_q, win_e_q, b_sum, e_sum;

  assign b_sum = win_b_q + WIN_W'(nb_i);
  assign e_sum = win_e_q + WIN_W'(miss_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      run_q    <= '0;
      win_b_q  <= '0;
      win_e_q  <= '0;
    end else if (valid_i) begin
      if (locked_q) begin
        if (e_sum >= WIN_W'(WIN_ERRS)) begin
          locked_q <= 1'b0;
          run_q    <= '0;
          win_b_q  <= '0;
          win_e_q  <= '0;
        end else if (b_sum >= WIN_W'(WIN_BITS)) begin
          win_b_q <= '0;
          win_e_q <= '0;
        end else begin
          win_b_q <= b_sum;
          win_e_q <= e_sum;
        end
      end else begin
        run_q <= run_next_i;
        if (run_next_i >= need_i) begin
          locked_q <= 1'b1;
          win_b_q  <= '0;
          win_e_q  <= '0;
        end
      end
    end
  end

  assign locked_o = locked_q;
  assign run_o    = run_q;
endmodule

// File: rtl/prbs_rx_cnt.sv
// Saturating live total with latch-and-restart into a holding register.
module prbs_rx_cnt #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] live_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] live_q, hold_q, base, nxt;
  logic [SUM_W-1:0] sum;

  always_comb begin
    base = latch_i ? '0 : live_q;
    sum  = {1'b0, base} + SUM_W'(en_i ? inc_i : '0);
    nxt  = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      live_q <= nxt;
      if (latch_i) hold_q <= live_q;
    end
  end

  assign live_o = live_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/prbs_rx.sv
module prbs_rx
  import prbs_rx_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int CNT_W   = 48,
  parameter int WORD_W  = 8,
  localparam int LEN_W  = $clog2(MAX_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         mode_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [MAX_LEN-1:0] taps_i,
  input  logic               latch_i,
  output logic               sync_o,
  output logic [CNT_W-1:0]   bit_hold_o,
  output logic [CNT_W-1:0]   err_hold_o
);
  localparam int RUN_W = $clog2(2 * MAX_LEN + 1);
  localparam int NB_W  = $clog2(WORD_W + 1);

  wmode_e             mode;
  logic [NB_W-1:0]    nb, miss;
  logic [MAX_LEN-1:0] len_mask, tap_eff, lfsr_q, lfsr_d;
  logic [RUN_W-1:0]   run_q, run_d, need;
  logic               locked;
  logic [CNT_W-1:0]   bit_live, err_live;

  assign mode = wmode_e'(mode_i);

  always_comb begin
    unique case (mode)
      WM_NIB:  nb = NB_W'(WORD_W / 2);
      WM_BYTE: nb = NB_W'(WORD_W);
      default: nb = NB_W'(1);
    endcase
  end

  assign len_mask = {MAX_LEN{1'b1}} >> (LEN_W'(MAX_LEN - 1) - len_i);
  assign tap_eff  = taps_i & len_mask;
  assign need     = RUN_W'(2 * (int'(len_i) + 1));

  prbs_rx_step #(
    .MAX_LEN(MAX_LEN), .WORD_W(WORD_W), .RUN_W(RUN_W), .NB_W(NB_W)
  ) u_step (
    .state_i (lfsr_q),
    .taps_i  (tap_eff),
    .data_i  (data_i),
    .nb_i    (nb),
    .locked_i(locked),
    .run_i   (run_q),
    .state_o (lfsr_d),
    .run_o   (run_d),
    .miss_o  (miss)
  );

  prbs_rx_sync #(
    .WORD_W(WORD_W), .RUN_W(RUN_W), .NB_W(NB_W)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .nb_i      (nb),
    .miss_i    (miss),
    .run_next_i(run_d),
    .need_i    (need),
    .locked_o  (locked),
    .run_o     (run_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lfsr_q <= '0;
    else if (valid_i) lfsr_q <= lfsr_d;
  end

  prbs_rx_cnt #(.CNT_W(CNT_W), .INC_W(NB_W)) u_bits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i & locked),
    .inc_i  (nb),
    .latch_i(latch_i),
    .live_o (bit_live),
    .hold_o (bit_hold_o)
  );

  prbs_rx_cnt #(.CNT_W(CNT_W), .INC_W(NB_W)) u_errs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i & locked),
    .inc_i  (miss),
    .latch_i(latch_i),
    .live_o (err_live),
    .hold_o (err_hold_o)
  );

  assign sync_o = locked;
endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             latch_i,
  input logic             sync_o,
  input logic [CNT_W-1:0] bit_hold_o,
  input logic [CNT_W-1:0] err_hold_o,
  input logic [CNT_W-1:0] bit_live_i,
  input logic [CNT_W-1:0] err_live_i
);
  a_r10_idle_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sync_o));

  a_r10_idle_totals: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !latch_i) |=> ($stable(bit_live_i) && $stable(err_live_i)));

  a_r6_no_count_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_o && !latch_i) |=> ($stable(bit_live_i) && $stable(err_live_i)));

  a_r7_err_le_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_live_i <= bit_live_i);

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> ($stable(bit_hold_o) && $stable(err_hold_o)));

  a_r8_latch_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (bit_hold_o == $past(bit_live_i) && err_hold_o == $past(err_live_i)));

  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> (bit_live_i >= $past(bit_live_i) && err_live_i >= $past(err_live_i)));
endmodule

bind prbs_rx prbs_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .latch_i   (latch_i),
  .sync_o    (sync_o),
  .bit_hold_o(bit_hold_o),
  .err_hold_o(err_hold_o),
  .bit_live_i(bit_live),
  .err_live_i(err_live)
);

// File: tb/prbs_rx_test.sv
module prbs_rx_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [7:0]  data_i = '0;
  logic [4:0]  len_i = '0;
  logic [31:0] taps_i = '0;
  logic        latch_i = 1'b0;
  logic        sync_o, sync_s;
  logic [47:0] bit_hold_o, err_hold_o;
  logic [9:0]  bh_s, eh_s;

  prbs_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i), .data_i(data_i),
    .len_i(len_i), .taps_i(taps_i), .latch_i(latch_i), .sync_o(sync_o),
    .bit_hold_o(bit_hold_o), .err_hold_o(err_hold_o));

  prbs_rx #(.CNT_W(10)) uut_sat (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i), .data_i(data_i),
    .len_i(len_i), .taps_i(taps_i), .latch_i(latch_i), .sync_o(sync_s),
    .bit_hold_o(bh_s), .err_hold_o(eh_s));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit          m_sync;
  logic [31:0] m_st, m_taps;
  int          m_run, m_wb, m_we, m_n;
  logic [47:0] m_lb, m_le, m_hb, m_he;
  // generator
  logic [31:0] g_st, g_taps;
  int          gbits, rerr;
  bit          pct_on;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] len_mask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [47:0] sat_add(logic [47:0] a, logic [47:0] b);
    logic [48:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[48] ? 48'hFFFF_FFFF_FFFF : s[47:0];
  endfunction

  function automatic logic [63:0] cap10(logic [47:0] v);
    return (v > 48'd1023) ? 64'd1023 : {16'd0, v};
  endfunction

  task automatic model(bit v, logic [1:0] mode, logic [7:0] d, bit lat);
    int nb, miss;
    bit was;
    logic p, b;
    logic [47:0] ib, ie;
    nb = (mode == 2'd1) ? 4 : (mode == 2'd2) ? 8 : 1;
    miss = 0; ib = '0; ie = '0; was = m_sync;
    if (v) begin
      for (int k = 0; k < nb; k++) begin
        b = d[nb-1-k];
        p = ^(m_st & m_taps);
        if (was) begin
          if (p != b) miss++;
          m_st = {m_st[30:0], p};
        end else begin
          if (p != b) m_run = 0;
          else if (m_run < 127) m_run++;
          m_st = {m_st[30:0], b};
        end
      end
      if (was) begin
        ib = 48'(nb); ie = 48'(miss);
        m_wb += nb; m_we += miss;
        if (m_we >= 6) begin m_sync = 0; m_run = 0; m_wb = 0; m_we = 0; end
        else if (m_wb >= 64) begin m_wb = 0; m_we = 0; end
      end else if (m_run >= 2 * m_n) begin
        m_sync = 1; m_wb = 0; m_we = 0;
      end
    end
    if (lat) begin m_hb = m_lb; m_he = m_le; m_lb = '0; m_le = '0; end
    m_lb = sat_add(m_lb, ib);
    m_le = sat_add(m_le, ie);
  endtask

  // entered at a falling edge, leaves at the next falling edge
  task automatic cyc(bit v, logic [1:0] mode, logic [7:0] d, bit lat, string req);
    valid_i = v; mode_i = mode; data_i = d; latch_i = lat;
    @(posedge clk);
    model(v, mode, d, lat);
    @(negedge clk);
    check(req, "sync_o", 64'(sync_o), 64'(m_sync));
    if (lat) begin
      check("R8", "bit_hold", 64'(bit_hold_o), 64'(m_hb));
      check("R8", "err_hold", 64'(err_hold_o), 64'(m_he));
      check("R9", "sat bit_hold", 64'(bh_s), cap10(m_hb));
      check("R9", "sat err_hold", 64'(eh_s), cap10(m_he));
    end
  endtask

  task automatic word(logic [1:0] mode, int flips, bit lat, string req);
    int nb;
    logic b;
    logic [7:0] d;
    nb = (mode == 2'd1) ? 4 : (mode == 2'd2) ? 8 : 1;
    d = 8'($urandom);
    for (int k = 0; k < nb; k++) begin
      b = ^(g_st & g_taps);
      g_st = {g_st[30:0], b};
      if (pct_on && (gbits % 100) == 37) b = ~b;
      if (k < flips) b = ~b;
      if (rerr > 0 && $urandom_range(999) < rerr) b = ~b;
      gbits++;
      d[nb-1-k] = b;
    end
    cyc(1'b1, mode, d, lat, req);
  endtask

  task automatic setup(int n, logic [31:0] rx_taps, logic [31:0] gen_taps, logic [31:0] seed);
    rst_ni = 1'b0; valid_i = 1'b0; latch_i = 1'b0;
    len_i = 5'(n - 1); taps_i = rx_taps;
    m_n = n; m_taps = rx_taps & len_mask(n);
    g_taps = gen_taps; g_st = seed; gbits = 0; rerr = 0; pct_on = 1'b0;
    m_sync = 0; m_st = '0; m_run = 0; m_wb = 0; m_we = 0;
    m_lb = '0; m_le = '0; m_hb = '0; m_he = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(64'd200000 * 64'd20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int drops;
    bit seen;
    void'($urandom(32'd1234));

    // R12 reset, R2 serial lock on a 7-stage register
    setup(7, 32'h60, 32'h60, 32'h5A);
    check("R12", "sync after reset", 64'(sync_o), 64'd0);
    check("R12", "bit_hold after reset", 64'(bit_hold_o), 64'd0);
    check("R12", "err_hold after reset", 64'(err_hold_o), 64'd0);
    for (int i = 0; i < 150; i++) word(2'd0, 0, 1'b0, "R2");
    check("R2", "serial locked", 64'(sync_o), 64'd1);
    word(2'd0, 0, 1'b1, "R6");

    // R11 taps above n ignored, R1 nibble words with gaps
    setup(7, 32'hFFFF_FF80 | 32'h60, 32'h60, 32'h3);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0) cyc(1'b0, 2'($urandom), 8'($urandom), 1'b0, "R10");
      else word(2'd1, 0, ($urandom_range(49) == 0), "R11");
    end
    word(2'd1, 0, 1'b1, "R1");
    check("R11", "nibble locked", 64'(sync_o), 64'd1);

    // R5 one error per hundred bits, byte words, 15-stage register
    setup(15, 32'h6000, 32'h6000, 32'h1);
    pct_on = 1'b1; drops = 0; seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      word(2'd2, 0, ($urandom_range(199) == 0), "R5");
      if (sync_o) seen = 1'b1;
      else if (seen) drops++;
    end
    check("R5", "lock drops at 1/100", 64'(drops), 64'd0);
    check("R5", "locked", 64'(sync_o), 64'd1);
    word(2'd2, 0, 1'b1, "R7");
    check("R9", "sat bit_hold pinned", 64'(bh_s), 64'd1023);
    pct_on = 1'b0;

    // R3 single flip counts once
    for (int i = 0; i < 20; i++) word(2'd2, 0, 1'b0, "R3");
    word(2'd2, 0, 1'b1, "R3");
    for (int i = 0; i < 9; i++) word(2'd2, 0, 1'b0, "R3");
    word(2'd2, 1, 1'b0, "R3");
    for (int i = 0; i < 10; i++) word(2'd2, 0, 1'b0, "R3");
    word(2'd2, 0, 1'b1, "R3");
    check("R3", "bits between latches", 64'(bit_hold_o), 64'd168);
    check("R3", "one flip one error", 64'(err_hold_o), 64'd1);

    // R4 five errors hold, six drop
    for (int i = 0; i < 20; i++) word(2'd2, 0, 1'b0, "R4");
    word(2'd2, 5, 1'b0, "R4");
    check("R4", "five errors keep lock", 64'(sync_o), 64'd1);
    for (int i = 0; i < 10; i++) word(2'd2, 0, 1'b0, "R4");
    word(2'd2, 6, 1'b0, "R4");
    check("R4", "six errors drop lock", 64'(sync_o), 64'd0);
    for (int i = 0; i < 100; i++) word(2'd2, 0, 1'b0, "R2");
    check("R2", "relock", 64'(sync_o), 64'd1);

    // R10 idle cycles change nothing
    word(2'd2, 0, 1'b1, "R10");
    for (int i = 0; i < 20; i++) cyc(1'b0, 2'($urandom), 8'($urandom), 1'b0, "R10");
    cyc(1'b0, 2'd2, 8'h00, 1'b1, "R10");
    check("R10", "idle bits", 64'(bit_hold_o), 64'd8);
    check("R10", "idle errs", 64'(err_hold_o), 64'd0);
    check("R10", "idle sync", 64'(sync_o), 64'd1);

    // R6 R7 random modes, gaps and errors on a 31-stage register
    setup(31, (32'h1 << 27) | (32'h1 << 30), (32'h1 << 27) | (32'h1 << 30), 32'hACE1);
    rerr = 5;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(4) == 0) cyc(1'b0, 2'($urandom), 8'($urandom), 1'b0, "R10");
      else word(2'($urandom), 0, ($urandom_range(99) == 0), "R6");
    end
    word(2'd2, 0, 1'b1, "R7");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule